// File: doc/BRIEF.md
# USB Device Event and Endpoint Handshake Controller

This block sits between the serial interface engine of a USB device and the CPU register bank. It turns strobes from the packet engine into interrupt flags: frame start, bus reset, suspend, wake-up and completed transfer. It holds the transmit and receive handshake status of every endpoint and the device address. It also runs a two-state link machine that measures bus idle time in millisecond ticks.

When a transfer completes, the block sets the addressed endpoint's status to NAK in the direction of that transfer. A SETUP sets both directions to NAK. The block then records the token type and endpoint number. While the completed-transfer flag is pending, these identifiers stay frozen, later transfer strobes are ignored, and every endpoint whose stored status is VALID is reported to the packet engine as NAK. Software reads the identifiers, rewrites the statuses it wants, and clears the flag.

The link machine has two states. In `LS_ACTIVE` it counts idle ticks. The transition `ACTIVE->SUSPENDED` is taken on the fourth consecutive tick with no bus activity, and it raises the suspend flag. The transition `SUSPENDED->ACTIVE` is taken on any bus activity, and it raises the wake-up flag. Activity in `LS_ACTIVE` restarts the count.

Top module: `usb_evt_ctrl`

## Requirements
- R1: After rst_n is released, all flags, the mask, the device address, every endpoint status, last_tok and last_ep read 0, and suspended is 0.
- R2: A bus_rst_stb sets the device address and every tx/rx status to 0 (disabled) and sets flag bit 2. It takes priority over any CPU write in the same cycle.
- R3: A write with wr_sel MSB set loads endpoint wr_sel[1:0]: tx status from wr_data[1:0] and rx status from wr_data[3:2]. The codes are 00 disabled, 01 stall, 10 NAK and 11 valid. The write is accepted while suspended and while flag bit 0 is pending.
- R4: Flag bit 1 (frame) is set one cycle after sof_stb or after resume_done_stb.
- R5: With no bus_activity, flag bit 3 is set and suspended rises on the fourth consecutive ms_tick, which is the tick that takes the idle count past 3. Activity restarts the count. The flag fires only once per idle period.
- R6: bus_activity while suspended sets flag bit 4 and clears suspended.
- R7: An accepted transfer sets flag bit 0 and forces status fields of endpoint xfer_ep to NAK. Token 01 (IN) forces tx, token 00 (OUT) and 11 force rx, and token 10 (SETUP) forces both. Other endpoints keep their status.
- R8: While flag bit 0 is set, tx_hs/rx_hs report NAK for every endpoint whose stored status is valid. They report the stored status otherwise.
- R9: last_tok and last_ep capture the token and endpoint of an accepted transfer. They stay frozen while flag bit 0 is set, and transfer strobes in that time change nothing.
- R10: Writing wr_sel=0 clears each flag whose wr_data bit is 0 and keeps flags written with 1. An event in the same cycle as a clear leaves its flag set.
- R11: irq is high exactly when some flag is set and its bit in the mask register (wr_sel=1, wr_data[4:0]) is 1.
- R12: Writing wr_sel=2 loads the 7-bit device address from wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_stb | input | 1 | Frame start strobe |
| resume_done_stb | input | 1 | End of resume sequence strobe |
| bus_rst_stb | input | 1 | USB bus reset strobe |
| bus_activity | input | 1 | Bus activity seen this cycle |
| ms_tick | input | 1 | Millisecond time base pulse |
| xfer_stb | input | 1 | Correct transfer completed |
| xfer_tok | input | 2 | Token of the transfer (00 OUT, 01 IN, 10 SETUP) |
| xfer_ep | input | 2 | Endpoint number of the transfer |
| wr_en | input | 1 | CPU register write enable |
| wr_sel | input | 3 | Register select (0 flags, 1 mask, 2 address, 4-7 endpoint) |
| wr_data | input | 7 | Write data |
| irq_flags | output | 5 | Flags: 0 transfer, 1 frame, 2 reset, 3 suspend, 4 wake |
| irq | output | 1 | Combined masked interrupt |
| dev_addr | output | 7 | Device address |
| tx_stat | output | 8 | Stored tx status, 2 bits per endpoint |
| rx_stat | output | 8 | Stored rx status, 2 bits per endpoint |
| tx_hs | output | 8 | Effective tx handshake to packet engine |
| rx_hs | output | 8 | Effective rx handshake to packet engine |
| last_tok | output | 2 | Token of last accepted transfer |
| last_ep | output | 2 | Endpoint of last accepted transfer |
| suspended | output | 1 | Link is in the suspended state |

## Verification
Every flag, status field, address, identifier and the suspended state is a register updated on the edge that samples its strobe. Each of them is therefore due exactly one clock after the stimulus, and irq follows in the same cycle as the flags. tx_hs and rx_hs are combinational from stored state, so they change in the same cycle as the flag or status that drives them. The bench drives every input on the falling edge, holds it for one full cycle, and samples on the next falling edge, so each check sees the value due exactly one rising edge after its stimulus.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    typedef enum logic [1:0] {
        HS_DIS   = 2'b00,
        HS_STALL = 2'b01,
        HS_NAK   = 2'b10,
        HS_VALID = 2'b11
    } hs_t;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'b00,
        TOK_IN    = 2'b01,
        TOK_SETUP = 2'b10,
        TOK_RSVD  = 2'b11
    } tok_t;

    typedef enum logic {
        LS_ACTIVE    = 1'b0,
        LS_SUSPENDED = 1'b1
    } link_st_t;

    localparam int NUM_FLG   = 5;
    localparam int FLG_XFER  = 0;
    localparam int FLG_FRAME = 1;
    localparam int FLG_BRST  = 2;
    localparam int FLG_SUSP  = 3;
    localparam int FLG_WAKE  = 4;

endpackage

// File: rtl/usb_evt_link_fsm.sv
module usb_evt_link_fsm
    import usb_evt_pkg::*;
#(
    parameter int IDLE_MS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_activity,
    input  logic ms_tick,
    output logic susp_evt,
    output logic wake_evt,
    output logic suspended
);
    localparam int CNT_W = $clog2(IDLE_MS + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_MS);

    link_st_t         state_q, state_d;
    logic [CNT_W-1:0] idle_q, idle_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_ACTIVE;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            idle_q  <= idle_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        idle_d   = idle_q;
        susp_evt = 1'b0;
        wake_evt = 1'b0;
        unique case (state_q)
            LS_ACTIVE: begin
                if (bus_activity) begin
                    idle_d = '0;
                end else if (ms_tick) begin
                    if (idle_q == CNT_LAST) begin
                        state_d  = LS_SUSPENDED;
                        susp_evt = 1'b1;
                        idle_d   = '0;
                    end else begin
                        idle_d = idle_q + 1'b1;
                    end
                end
            end
            LS_SUSPENDED: begin
                idle_d = '0;
                if (bus_activity) begin
                    state_d  = LS_ACTIVE;
                    wake_evt = 1'b1;
                end
            end
            default: state_d = LS_ACTIVE;
        endcase
    end

    assign suspended = (state_q == LS_SUSPENDED);

endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
    import usb_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_FLG-1:0] evt,
    input  logic               clr_we,
    input  logic [NUM_FLG-1:0] clr_keep,
    input  logic               mask_we,
    input  logic [NUM_FLG-1:0] mask_in,
    output logic [NUM_FLG-1:0] flags,
    output logic               irq
);
    logic [NUM_FLG-1:0] flags_q, mask_q, kept;

    always_comb begin
        kept = clr_we ? (flags_q & clr_keep) : flags_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= kept | evt;
            if (mask_we) mask_q <= mask_in;
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & mask_q);

endmodule

// File: rtl/usb_evt_ep_stat.sv
module usb_evt_ep_stat
    import usb_evt_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rst,
    input  logic                wr_we,
    input  logic [EP_W-1:0]     wr_ep,
    input  logic [3:0]          wr_val,
    input  logic                xfer_fire,
    input  logic [1:0]          xfer_tok,
    input  logic [EP_W-1:0]     xfer_ep,
    input  logic                xfer_pend,
    output logic [2*NUM_EP-1:0] tx_stat,
    output logic [2*NUM_EP-1:0] rx_stat,
    output logic [2*NUM_EP-1:0] tx_hs,
    output logic [2*NUM_EP-1:0] rx_hs
);
    logic force_tx, force_rx;

    always_comb begin
        force_tx = 1'b0;
        force_rx = 1'b0;
        unique case (tok_t'(xfer_tok))
            TOK_IN:    force_tx = 1'b1;
            TOK_SETUP: begin force_tx = 1'b1; force_rx = 1'b1; end
            TOK_OUT,
            TOK_RSVD:  force_rx = 1'b1;
            default:   force_rx = 1'b1;
        endcase
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        hs_t tx_q, rx_q, tx_d, rx_d;
        logic hit_wr, hit_xf;

        assign hit_wr = wr_we && (wr_ep == EP_W'(e));
        assign hit_xf = xfer_fire && (xfer_ep == EP_W'(e));

        always_comb begin
            tx_d = tx_q;
            rx_d = rx_q;
            if (hit_wr) begin
                tx_d = hs_t'(wr_val[1:0]);
                rx_d = hs_t'(wr_val[3:2]);
            end
            if (hit_xf && force_tx) tx_d = HS_NAK;
            if (hit_xf && force_rx) rx_d = HS_NAK;
            if (bus_rst) begin
                tx_d = HS_DIS;
                rx_d = HS_DIS;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx_q <= HS_DIS;
                rx_q <= HS_DIS;
            end else begin
                tx_q <= tx_d;
                rx_q <= rx_d;
            end
        end

        assign tx_stat[2*e +: 2] = tx_q;
        assign rx_stat[2*e +: 2] = rx_q;
        assign tx_hs[2*e +: 2]   = (xfer_pend && tx_q == HS_VALID) ? HS_NAK : tx_q;
        assign rx_hs[2*e +: 2]   = (xfer_pend && rx_q == HS_VALID) ? HS_NAK : rx_q;
    end

endmodule

// File: rtl/usb_evt_ctrl.sv
module usb_evt_ctrl
    import usb_evt_pkg::*;
#(
    parameter int NUM_EP  = 4,
    parameter int ADDR_W  = 7,
    parameter int IDLE_MS = 3,
    localparam int EP_W   = $clog2(NUM_EP),
    localparam int SEL_W  = EP_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_stb,
    input  logic                resume_done_stb,
    input  logic                bus_rst_stb,
    input  logic                bus_activity,
    input  logic                ms_tick,
    input  logic                xfer_stb,
    input  logic [1:0]          xfer_tok,
    input  logic [EP_W-1:0]     xfer_ep,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [ADDR_W-1:0]   wr_data,
    output logic [NUM_FLG-1:0]  irq_flags,
    output logic                irq,
    output logic [ADDR_W-1:0]   dev_addr,
    output logic [2*NUM_EP-1:0] tx_stat,
    output logic [2*NUM_EP-1:0] rx_stat,
    output logic [2*NUM_EP-1:0] tx_hs,
    output logic [2*NUM_EP-1:0] rx_hs,
    output logic [1:0]          last_tok,
    output logic [EP_W-1:0]     last_ep,
    output logic                suspended
);
    localparam logic [SEL_W-1:0] SEL_FLG  = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_MASK = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_ADDR = SEL_W'(2);

    logic               susp_evt, wake_evt, xfer_pend, xfer_fire;
    logic               wr_flg, wr_mask, wr_addr, wr_ep;
    logic [NUM_FLG-1:0] evt;
    logic [ADDR_W-1:0]  addr_q;
    logic [1:0]         tok_q;
    logic [EP_W-1:0]    ep_q;

    assign wr_flg  = wr_en && (wr_sel == SEL_FLG);
    assign wr_mask = wr_en && (wr_sel == SEL_MASK);
    assign wr_addr = wr_en && (wr_sel == SEL_ADDR);
    assign wr_ep   = wr_en && wr_sel[SEL_W-1];

    assign xfer_pend = irq_flags[FLG_XFER];
    assign xfer_fire = xfer_stb && !xfer_pend;

    always_comb begin
        evt            = '0;
        evt[FLG_XFER]  = xfer_fire;
        evt[FLG_FRAME] = sof_stb || resume_done_stb;
        evt[FLG_BRST]  = bus_rst_stb;
        evt[FLG_SUSP]  = susp_evt;
        evt[FLG_WAKE]  = wake_evt;
    end

    usb_evt_link_fsm #(.IDLE_MS(IDLE_MS)) u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_activity (bus_activity),
        .ms_tick      (ms_tick),
        .susp_evt     (susp_evt),
        .wake_evt     (wake_evt),
        .suspended    (suspended)
    );

    usb_evt_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_we   (wr_flg),
        .clr_keep (wr_data[NUM_FLG-1:0]),
        .mask_we  (wr_mask),
        .mask_in  (wr_data[NUM_FLG-1:0]),
        .flags    (irq_flags),
        .irq      (irq)
    );

    usb_evt_ep_stat #(.NUM_EP(NUM_EP)) u_ep (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst   (bus_rst_stb),
        .wr_we     (wr_ep),
        .wr_ep     (wr_sel[EP_W-1:0]),
        .wr_val    (wr_data[3:0]),
        .xfer_fire (xfer_fire),
        .xfer_tok  (xfer_tok),
        .xfer_ep   (xfer_ep),
        .xfer_pend (xfer_pend),
        .tx_stat   (tx_stat),
        .rx_stat   (rx_stat),
        .tx_hs     (tx_hs),
        .rx_hs     (rx_hs)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            tok_q  <= '0;
            ep_q   <= '0;
        end else begin
            if (bus_rst_stb)  addr_q <= '0;
            else if (wr_addr) addr_q <= wr_data;
            if (xfer_fire) begin
                tok_q <= xfer_tok;
                ep_q  <= xfer_ep;
            end
        end
    end

    assign dev_addr = addr_q;
    assign last_tok = tok_q;
    assign last_ep  = ep_q;

endmodule

// File: rtl/usb_evt_ctrl_chk.sv
module usb_evt_ctrl_chk #(
    parameter int NUM_EP = 4,
    parameter int ADDR_W = 7,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_rst_stb,
    input logic                frame_evt,
    input logic                bus_activity,
    input logic                xfer_stb,
    input logic                tok_in,
    input logic [EP_W-1:0]     xfer_ep,
    input logic                ctr_clr,
    input logic [4:0]          irq_flags,
    input logic [ADDR_W-1:0]   dev_addr,
    input logic [2*NUM_EP-1:0] tx_stat,
    input logic [2*NUM_EP-1:0] rx_stat,
    input logic [1:0]          last_tok,
    input logic [EP_W-1:0]     last_ep,
    input logic                suspended
);
    a_r2_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_stb |=> (dev_addr == '0 && tx_stat == '0 && rx_stat == '0 && irq_flags[2]));

    a_r4_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> irq_flags[1]);

    a_r5_susp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> irq_flags[3]);

    a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && bus_activity) |=> (!suspended && irq_flags[4]));

    a_r7_in_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !irq_flags[0] && !bus_rst_stb && tok_in)
        |=> (tx_stat[2*$past(xfer_ep) +: 2] == 2'b10));

    a_r9_frozen_ids: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[0] && !ctr_clr) |=> ($stable(last_tok) && $stable(last_ep)));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !irq_flags[0]) |=> irq_flags[0]);

endmodule

bind usb_evt_ctrl usb_evt_ctrl_chk #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst_stb  (bus_rst_stb),
    .frame_evt    (sof_stb || resume_done_stb),
    .bus_activity (bus_activity),
    .xfer_stb     (xfer_stb),
    .tok_in       (xfer_tok == 2'b01),
    .xfer_ep      (xfer_ep),
    .ctr_clr      (wr_en && wr_sel == '0 && !wr_data[0]),
    .irq_flags    (irq_flags),
    .dev_addr     (dev_addr),
    .tx_stat      (tx_stat),
    .rx_stat      (rx_stat),
    .last_tok     (last_tok),
    .last_ep      (last_ep),
    .suspended    (suspended)
);

// File: tb/usb_evt_ctrl_tb.sv
module usb_evt_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sof_stb = 0, resume_done_stb = 0, bus_rst_stb = 0;
    logic       bus_activity = 0, ms_tick = 0, xfer_stb = 0, wr_en = 0;
    logic [1:0] xfer_tok = 0, xfer_ep = 0;
    logic [2:0] wr_sel = 0;
    logic [6:0] wr_data = 0;
    logic [4:0] irq_flags;
    logic       irq, suspended;
    logic [6:0] dev_addr;
    logic [7:0] tx_stat, rx_stat, tx_hs, rx_hs;
    logic [1:0] last_tok, last_ep;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    usb_evt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sof_stb(sof_stb), .resume_done_stb(resume_done_stb),
        .bus_rst_stb(bus_rst_stb), .bus_activity(bus_activity), .ms_tick(ms_tick),
        .xfer_stb(xfer_stb), .xfer_tok(xfer_tok), .xfer_ep(xfer_ep), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_flags(irq_flags), .irq(irq),
        .dev_addr(dev_addr), .tx_stat(tx_stat), .rx_stat(rx_stat), .tx_hs(tx_hs),
        .rx_hs(rx_hs), .last_tok(last_tok), .last_ep(last_ep), .suspended(suspended)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [2:0] sel, input logic [6:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic set_ep(input int ep, input logic [1:0] tx, input logic [1:0] rx);
        cpu_wr({1'b1, 2'(ep)}, {3'b0, rx, tx});
    endtask

    task automatic xfer(input logic [1:0] tok, input logic [1:0] ep);
        @(negedge clk);
        xfer_stb = 1; xfer_tok = tok; xfer_ep = ep;
        @(negedge clk);
        xfer_stb = 0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1;
            @(negedge clk); ms_tick = 0;
        end
    endtask

    task automatic activity_pulse();
        @(negedge clk); bus_activity = 1;
        @(negedge clk); bus_activity = 0;
    endtask

    task automatic t_reset_state();
        chk("R1 flags", irq_flags, 0);
        chk("R1 irq", irq, 0);
        chk("R1 addr", dev_addr, 0);
        chk("R1 tx", tx_stat, 0);
        chk("R1 rx", rx_stat, 0);
        chk("R1 ids", {last_tok, last_ep}, 0);
        chk("R1 susp", suspended, 0);
    endtask

    task automatic t_addr_ep();
        cpu_wr(3'd2, 7'h5A);
        chk("R12 addr", dev_addr, 7'h5A);
        set_ep(2, 2'b01, 2'b11);
        chk("R3 ep2 tx", tx_stat[5:4], 2'b01);
        chk("R3 ep2 rx", rx_stat[5:4], 2'b11);
        chk("R3 others", {tx_stat[3:0], rx_stat[3:0]}, 0);
    endtask

    task automatic t_bus_reset();
        set_ep(1, 2'b11, 2'b10);
        @(negedge clk);
        bus_rst_stb = 1; wr_en = 1; wr_sel = 3'd2; wr_data = 7'h11;
        @(negedge clk);
        bus_rst_stb = 0; wr_en = 0;
        chk("R2 addr", dev_addr, 0);
        chk("R2 tx", tx_stat, 0);
        chk("R2 rx", rx_stat, 0);
        chk("R2 flag", irq_flags[2], 1);
        set_ep(0, 2'b00, 2'b11);
        chk("R3 ep0 rx valid", rx_stat[1:0], 2'b11);
        cpu_wr(3'd0, 7'h00);
        chk("R10 all cleared", irq_flags, 0);
    endtask

    task automatic t_frame();
        @(negedge clk); sof_stb = 1;
        @(negedge clk); sof_stb = 0;
        chk("R4 sof", irq_flags[1], 1);
        cpu_wr(3'd0, 7'h1D);
        chk("R10 clear bit1 only", irq_flags[1], 0);
        @(negedge clk); resume_done_stb = 1;
        @(negedge clk); resume_done_stb = 0;
        chk("R4 resume", irq_flags[1], 1);
        @(negedge clk);
        wr_en = 1; wr_sel = 0; wr_data = 0; sof_stb = 1;
        @(negedge clk);
        wr_en = 0; sof_stb = 0;
        chk("R10 event wins", irq_flags[1], 1);
        cpu_wr(3'd0, 7'h00);
    endtask

    task automatic t_irq();
        cpu_wr(3'd1, 7'h02);
        chk("R11 masked off", irq, 0);
        @(negedge clk); sof_stb = 1;
        @(negedge clk); sof_stb = 0;
        chk("R11 irq high", irq, 1);
        cpu_wr(3'd1, 7'h01);
        chk("R11 other mask", irq, 0);
        cpu_wr(3'd0, 7'h00);
        cpu_wr(3'd1, 7'h00);
    endtask

    task automatic t_suspend();
        activity_pulse();
        tick(3);
        chk("R5 not yet", {suspended, irq_flags[3]}, 0);
        activity_pulse();
        tick(3);
        chk("R5 restart", suspended, 0);
        tick(1);
        chk("R5 susp", {suspended, irq_flags[3]}, 2'b11);
        cpu_wr(3'd0, 7'h00);
        set_ep(3, 2'b10, 2'b01);
        chk("R3 write while suspended", {rx_stat[7:6], tx_stat[7:6]}, 4'b0110);
        tick(6);
        chk("R5 once per period", irq_flags[3], 0);
        activity_pulse();
        chk("R6 wake", {suspended, irq_flags[4]}, 2'b01);
        cpu_wr(3'd0, 7'h00);
    endtask

    task automatic t_xfer();
        set_ep(0, 2'b11, 2'b11);
        set_ep(1, 2'b11, 2'b11);
        set_ep(2, 2'b11, 2'b11);
        set_ep(3, 2'b01, 2'b11);
        xfer(2'b01, 2'd1);
        chk("R7 IN flag", irq_flags[0], 1);
        chk("R7 IN ep1", {rx_stat[3:2], tx_stat[3:2]}, 4'b1110);
        chk("R7 others", {tx_stat[7:4], tx_stat[1:0]}, 6'b011111);
        chk("R9 ids", {last_tok, last_ep}, 4'b0101);
        chk("R8 tx_hs", tx_hs, 8'b01_10_10_10);
        chk("R8 rx_hs", rx_hs, 8'b10_10_10_10);
        xfer(2'b10, 2'd2);
        chk("R9 frozen", {last_tok, last_ep}, 4'b0101);
        chk("R9 ignored", {rx_stat[5:4], tx_stat[5:4]}, 4'b1111);
        set_ep(0, 2'b11, 2'b00);
        chk("R3 write while pending", {rx_stat[1:0], tx_stat[1:0]}, 4'b0011);
        cpu_wr(3'd0, 7'h1E);
        chk("R10 clear xfer", irq_flags[0], 0);
        chk("R8 after clear", tx_hs[1:0], 2'b11);
        xfer(2'b10, 2'd2);
        chk("R7 SETUP", {rx_stat[5:4], tx_stat[5:4]}, 4'b1010);
        chk("R9 new ids", {last_tok, last_ep}, 4'b1010);
        cpu_wr(3'd0, 7'h00);
        xfer(2'b00, 2'd0);
        chk("R7 OUT", {rx_stat[1:0], tx_stat[1:0]}, 4'b1011);
        cpu_wr(3'd0, 7'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_addr_ep();
        t_bus_reset();
        t_frame();
        t_irq();
        t_suspend();
        t_xfer();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule